// File: doc/BRIEF.md
# Fault-Skipping Unit Select Switcher

This block sits between the module-field decode of a memory address and the enable lines of the physical memory units in a bank. A bank holds 2^Q_BITS logical units and SPARES spare units, so there are PHYS = 2^Q_BITS + SPARES physical select lines. A status vector marks which physical units are faulty. When the remap flag is set, each logical unit is steered onto a fault-free physical unit. Faulty units are skipped in ascending order, so every logical index at or above a fault moves up by one position per fault below it.

If the remap flag is clear, the encoded unit field is decoded straight onto the matching physical line. When the spares are used up and no fault-free unit is left for an index, the access raises a reference error and drives no select.

Two variants are chosen by `PER_BANK`. With `PER_BANK = 0`, one shared status vector marks whole rows for every bank. Selects are then combinational from the request, and `out_valid` follows `req_valid`. With `PER_BANK = 1`, a file of status words, one per bank, is indexed by the bank-select bits of the address. Outputs are then registered, and they appear one cycle after the request with a one-cycle `out_valid` pulse.

Top module: `unit_select_switcher`

## Requirements
- R1: After reset every status word is all zeros (no faulty unit), `out_valid` is 0, `phys_sel` is all zeros and `ref_err` is 0.
- R2: With `remap_en` = 0, an access with field value c drives exactly `phys_sel[c]` and `ref_err` = 0, whatever the status.
- R3: With `remap_en` = 1 and a status of all zeros, an access with field value c drives exactly `phys_sel[c]`.
- R4: With `remap_en` = 1 and a single status bit k set (1 = faulty), field values below k select unit c, and field values c >= k select unit c+1.
- R5: With `remap_en` = 1 and several faults, field value c selects the (c+1)-th fault-free physical unit counted from bit 0. A faulty unit is never selected, and at most one select bit is ever high.
- R6: If fewer than c+1 fault-free units exist, `ref_err` = 1 and `phys_sel` is all zeros.
- R7: In the per-bank variant, the status word used is the one addressed by `bank_idx`. A write to one bank leaves the mapping of every other bank unchanged.
- R8: In the per-bank variant, results appear at the clock edge after the request with `out_valid` = 1. A cycle without a request gives `out_valid` = 0 and `phys_sel` all zeros one edge later.
- R9: A status write is seen by accesses from the next cycle onward. An access in the same cycle as a write to its own bank uses the previous status.
- R10: In the shared variant, a single status word applies to every bank and `stat_bank` has no effect. Selects and `ref_err` follow the request in the same cycle, with `out_valid` = `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request strobe |
| bank_idx | input | BANK_BITS | Bank-select bits of the access address |
| unit_code | input | Q_BITS | Encoded unit field of the access |
| remap_en | input | 1 | Unit error flag; 1 enables fault skipping |
| stat_we | input | 1 | Status word write strobe |
| stat_bank | input | BANK_BITS | Bank whose status word is written (ignored in shared variant) |
| stat_fault | input | PHYS | New status word, bit j = 1 marks physical unit j faulty |
| phys_sel | output | PHYS | One-hot physical unit selects |
| ref_err | output | 1 | Spares exhausted for this access |
| out_valid | output | 1 | Result valid |

## Verification
A status write and an access can fall in the same cycle, and when both name the same bank the access must still be mapped with the old status word. The bench provokes this by writing a fault onto unit 0 of a bank while it requests unit field 0 of that bank in the same cycle. The scoreboard expects physical unit 0 for that request and unit 1 for the request that follows. The expected values come from a shadow copy of the status that the bench updates only after the write edge.

// File: rtl/unit_select_switcher.sv
module unit_select_switcher #(
  parameter int Q_BITS    = 3,
  parameter int SPARES    = 2,
  parameter int BANK_BITS = 2,
  parameter bit PER_BANK  = 1'b1,
  localparam int PHYS     = (1 << Q_BITS) + SPARES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [BANK_BITS-1:0] bank_idx,
  input  logic [Q_BITS-1:0]    unit_code,
  input  logic                 remap_en,
  input  logic                 stat_we,
  input  logic [BANK_BITS-1:0] stat_bank,
  input  logic [PHYS-1:0]      stat_fault,
  output logic [PHYS-1:0]      phys_sel,
  output logic                 ref_err,
  output logic                 out_valid
);
  localparam int NBANK = PER_BANK ? (1 << BANK_BITS) : 1;
  localparam int CW    = $clog2(PHYS + 1);

  logic [PHYS-1:0] stat_q [NBANK];
  logic [PHYS-1:0] stat_cur;
  logic [PHYS-1:0] good;
  logic [PHYS-1:0] map_sel;
  logic            map_err;
  logic [CW-1:0]   cnt;

  generate
    if (PER_BANK) begin : g_file
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int b = 0; b < NBANK; b++) stat_q[b] <= '0;
        end else if (stat_we) begin
          stat_q[stat_bank] <= stat_fault;
        end
      end
      assign stat_cur = stat_q[bank_idx];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          phys_sel  <= '0;
          ref_err   <= 1'b0;
          out_valid <= 1'b0;
        end else begin
          phys_sel  <= req_valid ? map_sel : '0;
          ref_err   <= req_valid & map_err;
          out_valid <= req_valid;
        end
      end
    end else begin : g_shared
      logic unused_bank;
      assign unused_bank = ^{bank_idx, stat_bank};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stat_q[0] <= '0;
        else if (stat_we) stat_q[0] <= stat_fault;
      end
      assign stat_cur  = stat_q[0];
      assign phys_sel  = req_valid ? map_sel : '0;
      assign ref_err   = req_valid & map_err;
      assign out_valid = req_valid;
    end
  endgenerate

  assign good = remap_en ? ~stat_cur : '1;

  always_comb begin
    cnt     = '0;
    map_sel = '0;
    for (int j = 0; j < PHYS; j++) begin
      if (good[j] && cnt == CW'(unit_code)) map_sel[j] = 1'b1;
      cnt = cnt + CW'(good[j]);
    end
    map_err = (cnt <= CW'(unit_code));
  end
endmodule

// File: rtl/unit_select_switcher_checks.sv
module unit_select_switcher_checks #(
  parameter int Q_BITS   = 3,
  parameter int PHYS     = 10,
  parameter bit PER_BANK = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              remap_en,
  input logic [Q_BITS-1:0] unit_code,
  input logic [PHYS-1:0]   stat_cur,
  input logic [PHYS-1:0]   map_sel,
  input logic [PHYS-1:0]   phys_sel,
  input logic              ref_err,
  input logic              out_valid
);
  a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phys_sel));

  a_r5_skip_faulty: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && remap_en) |-> ((map_sel & stat_cur) == '0));

  a_r6_err_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    ref_err |-> (phys_sel == '0));

  a_r3_clean_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && stat_cur == '0) |-> (map_sel == (PHYS'(1) << unit_code)));

  generate
    if (PER_BANK) begin : g_reg
      a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(req_valid && rst_n));
      a_r2_bypass_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(remap_en)) |-> !ref_err);
    end else begin : g_comb
      a_r10_valid_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == req_valid);
      a_r2_bypass_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        !remap_en |-> !ref_err);
    end
  endgenerate
endmodule

bind unit_select_switcher unit_select_switcher_checks #(
  .Q_BITS(Q_BITS), .PHYS(PHYS), .PER_BANK(PER_BANK)
) u_checks (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .remap_en(remap_en),
  .unit_code(unit_code), .stat_cur(stat_cur), .map_sel(map_sel),
  .phys_sel(phys_sel), .ref_err(ref_err), .out_valid(out_valid)
);

// File: tb/tb_unit_select_switcher.sv
module tb_unit_select_switcher;
  localparam int CLK_PERIOD = 10;
  localparam int QB = 3;
  localparam int BB = 2;
  localparam int P  = (1 << QB) + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          req_valid = 0, remap_en = 0, stat_we = 0;
  logic [BB-1:0] bank_idx = 0, stat_bank = 0;
  logic [QB-1:0] unit_code = 0;
  logic [P-1:0]  stat_fault = 0;
  logic [P-1:0]  phys_sel;
  logic          ref_err, out_valid;

  unit_select_switcher #(.Q_BITS(QB), .SPARES(2), .BANK_BITS(BB), .PER_BANK(1'b1)) dut (
    .clk, .rst_n, .req_valid, .bank_idx, .unit_code, .remap_en, .stat_we,
    .stat_bank, .stat_fault, .phys_sel, .ref_err, .out_valid);

  logic          sh_req = 0, sh_en = 0, sh_we = 0;
  logic [BB-1:0] sh_bank = 0, sh_wbank = 0;
  logic [QB-1:0] sh_code = 0;
  logic [P-1:0]  sh_data = 0;
  logic [P-1:0]  sh_sel;
  logic          sh_err, sh_valid;

  unit_select_switcher #(.Q_BITS(QB), .SPARES(2), .BANK_BITS(BB), .PER_BANK(1'b0)) dut_sh (
    .clk, .rst_n, .req_valid(sh_req), .bank_idx(sh_bank), .unit_code(sh_code),
    .remap_en(sh_en), .stat_we(sh_we), .stat_bank(sh_wbank), .stat_fault(sh_data),
    .phys_sel(sh_sel), .ref_err(sh_err), .out_valid(sh_valid));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [P-1:0] shadow [4];
  logic [P:0]   exp_q [$];
  string        tag_q [$];

  function automatic logic [P:0] model(input logic [P-1:0] st, input int code, input logic en);
    int n = 0;
    logic [P-1:0] s = '0;
    for (int j = 0; j < P; j++) begin
      if (!en || !st[j]) begin
        if (n == code) s[j] = 1'b1;
        n++;
      end
    end
    return {(n <= code), s};
  endfunction

  task automatic access(input int b, input int c, input logic en, input string tag);
    @(negedge clk);
    stat_we = 0; req_valid = 1; bank_idx = BB'(b); unit_code = QB'(c); remap_en = en;
    exp_q.push_back(model(shadow[b], c, en));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0; stat_we = 0;
  endtask

  task automatic write_st(input int b, input logic [P-1:0] d);
    @(negedge clk);
    req_valid = 0; stat_we = 1; stat_bank = BB'(b); stat_fault = d;
    @(negedge clk);
    stat_we = 0; shadow[b] = d;
  endtask

  task automatic access_and_write(input int b, input int c, input logic [P-1:0] d, input string tag);
    @(negedge clk);
    req_valid = 1; bank_idx = BB'(b); unit_code = QB'(c); remap_en = 1;
    stat_we = 1; stat_bank = BB'(b); stat_fault = d;
    exp_q.push_back(model(shadow[b], c, 1'b1));
    tag_q.push_back(tag);
    @(negedge clk);
    stat_we = 0; req_valid = 0; shadow[b] = d;
  endtask

  task automatic sh_check(input int b, input int c, input logic en, input logic [P-1:0] st, input string tag);
    logic [P:0] e;
    @(negedge clk);
    sh_req = 1; sh_bank = BB'(b); sh_code = QB'(c); sh_en = en;
    e = model(st, c, en);
    #1;
    checks++;
    if ({sh_err, sh_sel} !== e || sh_valid !== 1'b1) begin
      fails++;
      $display("FAIL %s: bank %0d code %0d got err=%b sel=%b valid=%b expected err=%b sel=%b valid=1",
               tag, b, c, sh_err, sh_sel, sh_valid, e[P], e[P-1:0]);
    end
  endtask

  always @(posedge clk) begin
    logic [P:0] e;
    string t;
    #1;
    if (rst_n && !done) begin
      checks++;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (out_valid !== 1'b1 || {ref_err, phys_sel} !== e) begin
          fails++;
          $display("FAIL %s: got valid=%b err=%b sel=%b expected valid=1 err=%b sel=%b",
                   t, out_valid, ref_err, phys_sel, e[P], e[P-1:0]);
        end
      end else if (out_valid !== 1'b0 || phys_sel !== '0) begin
        fails++;
        $display("FAIL R8 idle: got valid=%b sel=%b expected valid=0 sel=0", out_valid, phys_sel);
      end
    end
  end

  initial begin
    for (int b = 0; b < 4; b++) shadow[b] = '0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 0 || phys_sel !== '0 || ref_err !== 0) begin
      fails++;
      $display("FAIL R1 reset: got valid=%b sel=%b err=%b expected 0 0 0", out_valid, phys_sel, ref_err);
    end
    @(negedge clk); rst_n = 1;

    for (int c = 0; c < 8; c++) access(0, c, 1'b1, "R1/R3 clean decode");
    idle(); idle();

    write_st(1, P'(1) << 3);
    for (int c = 0; c < 8; c++) access(1, c, 1'b0, "R2 remap off");
    for (int c = 0; c < 8; c++) access(1, c, 1'b1, "R4 single fault at 3");
    idle();

    write_st(2, (P'(1) << 0) | (P'(1) << 4) | (P'(1) << 5));
    for (int c = 0; c < 7; c++) access(2, c, 1'b1, "R5 three faults");
    access(2, 7, 1'b1, "R6 spares exhausted");
    access(2, 7, 1'b0, "R2 no error when off");
    idle();

    write_st(3, (P'(1) << 1) | (P'(1) << (P-1)));
    for (int c = 0; c < 8; c++) access(3, c, 1'b1, "R5 fault in last spare");
    for (int c = 0; c < 8; c++) access(0, c, 1'b1, "R7 other bank untouched");
    idle(); idle();

    access_and_write(0, 0, P'(1), "R9 same-cycle write uses old status");
    access(0, 0, 1'b1, "R9 write visible next access");
    access(0, 7, 1'b1, "R9 shifted top index");
    idle(); idle();

    @(negedge clk);
    sh_we = 1; sh_wbank = 2'd1; sh_data = P'(1) << 2;
    @(negedge clk);
    sh_we = 0;
    sh_check(3, 2, 1'b1, P'(1) << 2, "R10 shared status other bank");
    sh_check(0, 1, 1'b1, P'(1) << 2, "R10 shared below fault");
    sh_check(2, 7, 1'b1, P'(1) << 2, "R10 shared top index");
    @(negedge clk);
    sh_we = 1; sh_wbank = 2'd3; sh_data = P'(7);
    @(negedge clk);
    sh_we = 0;
    sh_check(1, 7, 1'b1, P'(7), "R10/R6 shared exhausted");
    sh_check(1, 4, 1'b0, P'(7), "R10/R2 shared remap off");
    @(negedge clk);
    sh_req = 0;
    #1;
    checks++;
    if (sh_valid !== 0 || sh_sel !== '0) begin
      fails++;
      $display("FAIL R10 no request: got valid=%b sel=%b expected 0 0", sh_valid, sh_sel);
    end

    idle(); idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule